// File: doc/BRIEF.md
# FIFO-Buffered SPI Master

This block is a register-mapped SPI master. Software writes words into a transmit queue, chooses clock polarity, clock phase and bit order in a control register, and selects a target device through an active-low slave-select register. A hold bit in the control register stops the serial engine from starting. Software can therefore fill the queue completely and then clear the hold bit to send the whole burst back to back.

Each word sent on the serial data output is matched by a word captured from the serial data input. That word is placed in a receive queue and popped when software reads the receive data register. Two single-cycle event outputs report when a burst has completely left the shifter and when a received word was lost to a full queue. A status bit records a fault when another master drives the bus select input while this block is enabled as master. The word width, queue depth, serial clock divider and number of slave-select lines are all fixed by parameters.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, control reads 0x100 (hold set, everything else clear), status reads 0x05, slave-select reads all ones, every ss_no line is high and sclk_o is low.
- R2: Register map. Control is at 0x60, status at 0x64, transmit data at 0x68, receive data at 0x6C and slave select at 0x70. Control bits: 1 enable, 2 master, 3 CPOL, 4 CPHA, 5 transmit-queue clear, 6 receive-queue clear, 7 manual select, 8 hold, 9 LSB first. Status bits: 0 receive empty, 1 receive full, 2 transmit empty, 3 transmit full, 4 mode fault.
- R3: No word starts shifting while the hold bit is set, even when the transmit queue holds data. Clearing the bit sends every queued word.
- R4: When idle, sclk_o rests at CPOL. Each data bit is stable on mosi_o at the sampling edge: the leading edge when CPHA is 0, the trailing edge when CPHA is 1. miso_i is captured at that same edge.
- R5: Words are sent most significant bit first, or least significant bit first when control bit 9 is set. Received words are assembled in the same order.
- R6: With manual select and enable both set, ss_no equals the low bits of the slave-select register at all times. Otherwise ss_no equals those bits only while a word is shifting and is all ones when the shifter is idle.
- R7: Writing 1 to a queue-clear bit empties that queue once. The bit reads back 0, and the queue accepts new words immediately afterwards.
- R8: A read of the receive data register returns the oldest word and pops it. A read while the queue is empty returns 0 and changes nothing.
- R9: A write to the transmit data register while the transmit queue is full is discarded.
- R10: A word that completes while the receive queue is full is dropped, and rx_ovr_o pulses for one cycle.
- R11: tx_done_o pulses once, when a word finishes shifting with the transmit queue empty. It does not pulse when the queue first drains.
- R12: mf_ni low while enable and master are both set raises status bit 4. The bit stays set until the status register is read.
- R13: A word starts only when enable and master are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | NUM_SS | Slave selects, active low |
| mf_ni | input | 1 | Bus select from another master, active low |
| tx_done_o | output | 1 | Burst finished pulse |
| rx_ovr_o | output | 1 | Receive overrun pulse |

## Verification
A wrong edge count or a wrong phase choice in the shifter shows up within the first word time. The bench rebuilds each word from mosi_o at the sampling edges, so the rebuilt word comes out shifted or reversed. A miscounted queue shows up as a missing or extra word on the wire, or as a wrong status flag, once the burst ends. A stale slave-select or hold state shows up on ss_no or as shifting activity during the hold window, within one word time.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam logic [7:0] A_CTRL = 8'h60;
  localparam logic [7:0] A_STAT = 8'h64;
  localparam logic [7:0] A_TXD  = 8'h68;
  localparam logic [7:0] A_RXD  = 8'h6C;
  localparam logic [7:0] A_SSEL = 8'h70;

  localparam int C_EN = 1, C_MST = 2, C_CPOL = 3, C_CPHA = 4, C_TXCLR = 5;
  localparam int C_RXCLR = 6, C_MAN = 7, C_HOLD = 8, C_LSB = 9;

  localparam int S_RXE = 0, S_RXF = 1, S_TXE = 2, S_TXF = 3, S_MF = 4;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (clr_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wp_q] <= wdata_i;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W       = 8,
  parameter int CLK_DIV = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] word_i,
  input  logic         cpol_i,
  input  logic         cpha_i,
  input  logic         lsb_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rx_word_o,
  output logic         sclk_o,
  output logic         mosi_o
);
  localparam int EW = $clog2(2 * W);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic          busy_q, sclk_q, mosi_q;
  logic [DW-1:0] div_q;
  logic [EW-1:0] edge_q;
  logic [W-1:0]  tx_sr, rx_sr, rx_samp;
  logic          tick, lead, last, out_edge, samp_edge, nbit;

  function automatic logic [W-1:0] sh(input logic l, input logic [W-1:0] v);
    return l ? {1'b0, v[W-1:1]} : {v[W-2:0], 1'b0};
  endfunction

  assign tick      = busy_q && (div_q == DW'(CLK_DIV - 1));
  assign lead      = ~edge_q[0];
  assign last      = (edge_q == EW'(2 * W - 1));
  // phase 1 drives on leading edges; phase 0 drives at load and on trailing edges
  assign out_edge  = cpha_i ? lead : (!lead && !last);
  assign samp_edge = cpha_i ? !lead : lead;
  assign nbit      = lsb_i ? tx_sr[0] : tx_sr[W-1];
  assign rx_samp   = lsb_i ? {miso_i, rx_sr[W-1:1]} : {rx_sr[W-2:0], miso_i};

  assign busy_o    = busy_q;
  assign done_o    = tick && last;
  assign rx_word_o = cpha_i ? rx_samp : rx_sr;
  assign sclk_o    = sclk_q;
  assign mosi_o    = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0;
      div_q  <= '0;   edge_q <= '0;   tx_sr  <= '0; rx_sr <= '0;
    end else if (!busy_q) begin
      sclk_q <= cpol_i;
      div_q  <= '0;
      edge_q <= '0;
      if (start_i) begin
        busy_q <= 1'b1;
        rx_sr  <= '0;
        if (cpha_i) begin
          tx_sr <= word_i;
        end else begin
          mosi_q <= lsb_i ? word_i[0] : word_i[W-1];
          tx_sr  <= sh(lsb_i, word_i);
        end
      end
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 1'b1;
        if (out_edge) begin
          mosi_q <= nbit;
          tx_sr  <= sh(lsb_i, tx_sr);
        end
        if (samp_edge) rx_sr <= rx_samp;
        if (last) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int CLK_DIV    = 2,
  parameter int NUM_SS     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_no,
  input  logic              mf_ni,
  output logic              tx_done_o,
  output logic              rx_ovr_o
);
  logic en_q, mst_q, cpol_q, cpha_q, man_q, hold_q, lsb_q, mf_q;
  logic [NUM_SS-1:0] ss_q;
  logic wr, rd, tx_clr, rx_clr, tx_push, tx_pop, rx_pop, start;
  logic tx_empty, tx_full, rx_empty, rx_full, busy, done;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign tx_clr  = wr && (addr_i == A_CTRL) && wdata_i[C_TXCLR];
  assign rx_clr  = wr && (addr_i == A_CTRL) && wdata_i[C_RXCLR];
  assign tx_push = wr && (addr_i == A_TXD);
  assign rx_pop  = rd && (addr_i == A_RXD);
  assign start   = !busy && en_q && mst_q && !hold_q && !tx_empty;
  assign tx_pop  = start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {en_q, mst_q, cpol_q, cpha_q, man_q, lsb_q} <= '0;
      hold_q <= 1'b1;
      ss_q   <= '1;
      mf_q   <= 1'b0;
    end else begin
      if (wr && addr_i == A_CTRL) begin
        en_q   <= wdata_i[C_EN];   mst_q <= wdata_i[C_MST];
        cpol_q <= wdata_i[C_CPOL]; cpha_q <= wdata_i[C_CPHA];
        man_q  <= wdata_i[C_MAN];  hold_q <= wdata_i[C_HOLD];
        lsb_q  <= wdata_i[C_LSB];
      end
      if (wr && addr_i == A_SSEL) ss_q <= wdata_i[NUM_SS-1:0];
      mf_q <= (mf_q && !(rd && addr_i == A_STAT)) || (en_q && mst_q && !mf_ni);
    end
  end

  spi_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk_i, .rst_ni, .clr_i(tx_clr), .push_i(tx_push), .wdata_i(wdata_i[DATA_W-1:0]),
    .pop_i(tx_pop), .rdata_o(tx_head), .empty_o(tx_empty), .full_o(tx_full));

  spi_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk_i, .rst_ni, .clr_i(rx_clr), .push_i(done), .wdata_i(rx_word),
    .pop_i(rx_pop), .rdata_o(rx_head), .empty_o(rx_empty), .full_o(rx_full));

  spi_shifter #(.W(DATA_W), .CLK_DIV(CLK_DIV)) u_shf (
    .clk_i, .rst_ni, .start_i(start), .word_i(tx_head), .cpol_i(cpol_q),
    .cpha_i(cpha_q), .lsb_i(lsb_q), .miso_i, .busy_o(busy), .done_o(done),
    .rx_word_o(rx_word), .sclk_o, .mosi_o);

  assign ss_no     = ((en_q && man_q) || busy) ? ss_q : '1;
  assign tx_done_o = done && tx_empty;
  assign rx_ovr_o  = done && rx_full && !rx_pop;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[C_EN]   = en_q;   rdata_o[C_MST]  = mst_q;
        rdata_o[C_CPOL] = cpol_q; rdata_o[C_CPHA] = cpha_q;
        rdata_o[C_MAN]  = man_q;  rdata_o[C_HOLD] = hold_q;
        rdata_o[C_LSB]  = lsb_q;
      end
      A_STAT: begin
        rdata_o[S_RXE] = rx_empty; rdata_o[S_RXF] = rx_full;
        rdata_o[S_TXE] = tx_empty; rdata_o[S_TXF] = tx_full;
        rdata_o[S_MF]  = mf_q;
      end
      A_RXD:   rdata_o[DATA_W-1:0] = rx_empty ? '0 : rx_head;
      A_SSEL: begin
        rdata_o = '1;
        rdata_o[NUM_SS-1:0] = ss_q;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int NUM_SS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy,
  input logic              en_q,
  input logic              man_q,
  input logic              hold_q,
  input logic              cpol_q,
  input logic [NUM_SS-1:0] ss_no,
  input logic              sclk_o,
  input logic              tx_full,
  input logic              tx_push,
  input logic              tx_pop,
  input logic              tx_clr,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              rx_ovr_o,
  input logic              tx_done_o
);
  p_hold_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && hold_q) |=> !busy);

  p_sclk_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> (sclk_o == $past(cpol_q)));

  p_ss_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && !(en_q && man_q)) |-> (&ss_no));

  p_full_write_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full && tx_push && !tx_pop && !tx_clr) |=> tx_full);

  p_overrun_when_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovr_o |-> rx_full);

  p_done_last_word_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> (tx_empty && busy));

  p_done_ends_shift_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !busy);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.NUM_SS(NUM_SS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy(busy), .en_q(en_q), .man_q(man_q),
  .hold_q(hold_q), .cpol_q(cpol_q), .ss_no(ss_no), .sclk_o(sclk_o),
  .tx_full(tx_full), .tx_push(tx_push), .tx_pop(tx_pop), .tx_clr(tx_clr),
  .tx_empty(tx_empty), .rx_full(rx_full), .rx_ovr_o(rx_ovr_o),
  .tx_done_o(tx_done_o));

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8, DEPTH = 4, DIV = 2, NSS = 4;
  localparam int WORD_T = 2 * W * DIV + 8;

  logic clk_i = 0, rst_ni = 0, req_i = 0, we_i = 0, mf_ni = 1;
  logic [7:0] addr_i = 0;
  logic [31:0] wdata_i = 0, rdata_o;
  logic sclk_o, mosi_o, miso_i, tx_done_o, rx_ovr_o;
  logic [NSS-1:0] ss_no;

  int n_tests = 0, n_fail = 0, mon_words = 0, nb = 0, done_cnt = 0, ovr_cnt = 0;
  logic mon_on = 0, cpol_b = 0, cpha_b = 0, lsb_b = 0, inv_b = 0;
  logic [NSS-1:0] ss_exp = 4'b1110;
  logic [W-1:0] bits = 0;
  logic [W-1:0] tx_q[$], rx_q[$];
  logic [31:0] d;

  assign miso_i = mosi_o ^ inv_b;
  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  spi_fifo_master #(.DATA_W(W), .FIFO_DEPTH(DEPTH), .CLK_DIV(DIV), .NUM_SS(NSS)) dut_i (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .sclk_o, .mosi_o,
    .miso_i, .ss_no, .mf_ni, .tx_done_o, .rx_ovr_o);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = v;
    @(negedge clk_i); req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    #1 v = rdata_o;
    @(negedge clk_i); req_i = 0;
  endtask

  // driver: push expected items for the scoreboard
  task automatic send(input logic [W-1:0] w, input bit exp_tx, input bit exp_rx);
    wr(8'h68, {24'h0, w});
    if (exp_tx) tx_q.push_back(lsb_b ? rev(w) : w);
    if (exp_rx) rx_q.push_back(w ^ {W{inv_b}});
  endtask

  task automatic drain_rx(input string req);
    while (rx_q.size() > 0) begin
      logic [W-1:0] e;
      e = rx_q.pop_front();
      rd(8'h6C, d);
      check(d == {24'h0, e}, req, d, {24'h0, e});
    end
  endtask

  function automatic logic [31:0] ctl(input bit hold, input bit man = 0);
    return 32'h6 | (32'(cpol_b) << 3) | (32'(cpha_b) << 4) | (32'(man) << 7)
         | (32'(hold) << 8) | (32'(lsb_b) << 9);
  endfunction

  // monitor: rebuild each word from mosi at the sampling edge
  always @(sclk_o) begin
    if (mon_on && rst_ni) begin
      if ((sclk_o != cpol_b) ^ cpha_b) begin
        bits = {bits[W-2:0], mosi_o};
        nb++;
        if (nb == 1) check(ss_no == ss_exp, "R6 ss during shift", 32'(ss_no), 32'(ss_exp));
        if (nb == W) begin
          nb = 0;
          mon_words++;
          if (tx_q.size() == 0) check(0, "R3 unexpected word", 32'(bits), 0);
          else begin
            logic [W-1:0] e;
            e = tx_q.pop_front();
            check(bits == e, "R4/R5 mosi word", 32'(bits), 32'(e));
          end
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (tx_done_o) done_cnt++;
    if (rx_ovr_o) ovr_cnt++;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int w0, dc0;
    repeat (3) @(negedge clk_i);
    #1;
    check(ss_no == '1, "R1 ss reset", 32'(ss_no), 32'hF);
    check(sclk_o == 0, "R1 sclk reset", 32'(sclk_o), 0);
    rst_ni = 1;
    rd(8'h60, d); check(d == 32'h100, "R1 ctrl reset", d, 32'h100);
    rd(8'h64, d); check(d == 32'h05, "R1 status reset", d, 32'h05);
    rd(8'h70, d); check(d == 32'hFFFF_FFFF, "R1 ssel reset", d, 32'hFFFF_FFFF);

    // R3 hold then release, R11 single done pulse
    wr(8'h70, 32'hFFFF_FFFE);
    wr(8'h60, ctl(1));
    mon_on = 1;
    send(8'hA5, 1, 1); send(8'h3C, 1, 1); send(8'h81, 1, 1);
    repeat (WORD_T * 2) @(negedge clk_i);
    check(mon_words == 0, "R3 hold blocks shift", mon_words, 0);
    check(ss_no == '1, "R3 ss idle under hold", 32'(ss_no), 32'hF);
    rd(8'h64, d); check(d[2] == 0, "R3 tx queue kept", d, 0);
    wr(8'h60, ctl(0));
    repeat (WORD_T * 3) @(negedge clk_i);
    check(mon_words == 3, "R3 release drains", mon_words, 3);
    check(done_cnt == 1, "R11 one done pulse", done_cnt, 1);
    drain_rx("R8 rx pop order");
    rd(8'h6C, d); check(d == 0, "R8 empty read zero", d, 0);
    rd(8'h64, d); check(d == 32'h05, "R8 status after drain", d, 32'h05);

    // R4/R5 all modes and both orders
    for (int m = 0; m < 8; m++) begin
      mon_on = 0;
      cpol_b = m[0]; cpha_b = m[1]; lsb_b = m[2]; inv_b = ~inv_b;
      wr(8'h60, ctl(1));
      repeat (4) @(negedge clk_i);
      check(sclk_o == cpol_b, "R4 sclk idle level", 32'(sclk_o), 32'(cpol_b));
      nb = 0; mon_on = 1;
      send(8'h96 ^ W'(m * 17), 1, 1); send(8'h1E + W'(m), 1, 1);
      wr(8'h60, ctl(0));
      repeat (WORD_T * 2) @(negedge clk_i);
      check(sclk_o == cpol_b, "R4 sclk back idle", 32'(sclk_o), 32'(cpol_b));
      drain_rx("R4/R5 miso capture");
    end
    mon_on = 0; cpol_b = 0; cpha_b = 0; lsb_b = 0; inv_b = 0;
    wr(8'h60, ctl(1));
    repeat (4) @(negedge clk_i);
    nb = 0; mon_on = 1;

    // R6 manual select
    wr(8'h70, 32'hFFFF_FFFB); ss_exp = 4'b1011;
    wr(8'h60, ctl(1, 1));
    @(negedge clk_i);
    check(ss_no == 4'b1011, "R6 manual idle assert", 32'(ss_no), 32'hB);
    send(8'h5A, 1, 1);
    wr(8'h60, ctl(0, 1));
    repeat (WORD_T) @(negedge clk_i);
    check(ss_no == 4'b1011, "R6 manual holds after word", 32'(ss_no), 32'hB);
    drain_rx("R6 rx");
    wr(8'h60, ctl(1, 0));
    @(negedge clk_i);
    check(ss_no == 4'hF, "R6 auto idle release", 32'(ss_no), 32'hF);
    wr(8'h70, 32'hFFFF_FFFE); ss_exp = 4'b1110;

    // R9 full write ignored, R10 overrun
    w0 = mon_words;
    for (int i = 0; i < 4; i++) send(8'h10 + W'(i), 1, 1);
    send(8'hEE, 0, 0);
    rd(8'h64, d); check(d[3] == 1, "R9 tx full flag", d, 32'h8);
    wr(8'h60, ctl(0));
    repeat (WORD_T * 5) @(negedge clk_i);
    check(mon_words - w0 == 4, "R9 only four words sent", mon_words - w0, 4);
    rd(8'h64, d); check(d[1:0] == 2'b10, "R2 rx full flag", d, 32'h2);
    check(ovr_cnt == 0, "R10 no early overrun", ovr_cnt, 0);
    send(8'h77, 1, 0);
    repeat (WORD_T) @(negedge clk_i);
    check(ovr_cnt == 1, "R10 overrun pulse", ovr_cnt, 1);
    drain_rx("R10 kept words");

    // R7 queue clears
    wr(8'h60, ctl(1));
    w0 = mon_words;
    send(8'h01, 0, 0); send(8'h02, 0, 0);
    wr(8'h60, ctl(1) | 32'h20);
    rd(8'h64, d); check(d[2] == 1, "R7 tx cleared", d, 32'h4);
    rd(8'h60, d); check(d[6:5] == 0, "R7 clear bits read 0", d, 0);
    send(8'hC3, 1, 0);
    rd(8'h64, d); check(d[2] == 0, "R7 tx accepts after clear", d, 0);
    wr(8'h60, ctl(0));
    repeat (WORD_T) @(negedge clk_i);
    check(mon_words - w0 == 1, "R7 cleared words not sent", mon_words - w0, 1);
    rd(8'h64, d); check(d[0] == 0, "R7 rx holds word", d, 0);
    wr(8'h60, ctl(0) | 32'h40);
    rd(8'h64, d); check(d[0] == 1, "R7 rx cleared", d, 32'h1);

    // R13 enable and master both required
    w0 = mon_words; dc0 = done_cnt;
    wr(8'h60, 32'h004);
    send(8'h99, 0, 0);
    repeat (WORD_T) @(negedge clk_i);
    wr(8'h60, 32'h002);
    repeat (WORD_T) @(negedge clk_i);
    check(mon_words == w0, "R13 no shift without both", mon_words - w0, 0);
    rd(8'h64, d); check(d[2] == 0, "R13 word still queued", d, 0);
    check(done_cnt == dc0, "R13 no done pulse", done_cnt - dc0, 0);
    wr(8'h60, 32'h126);

    // R12 mode fault
    wr(8'h60, 32'h100);
    @(negedge clk_i); mf_ni = 0; @(negedge clk_i); mf_ni = 1;
    rd(8'h64, d); check(d[4] == 0, "R12 no fault when disabled", d, 0);
    wr(8'h60, 32'h106);
    @(negedge clk_i); mf_ni = 0; @(negedge clk_i); mf_ni = 1;
    rd(8'h64, d); check(d[4] == 1, "R12 fault flagged", d, 32'h10);
    rd(8'h64, d); check(d[4] == 0, "R12 cleared by read", d, 0);

    check(tx_q.size() == 0, "R3 all expected words seen", tx_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule